// File: doc/BRIEF.md
# SPI User-Mode Transfer Engine

This block is a memory-mapped SPI master that runs one full-duplex transfer per command. Software fills a shared 64-byte data buffer with 32-bit register writes. It then programs how many bits to shift, picks whether chip select stays asserted when the command ends, and sets a start bit. The engine shifts the buffer out on MOSI in SPI mode 0. At the same time it samples MISO back into the very bit positions it has just sent. When the last bit has gone out, a sticky done flag is raised.

Transfers longer than the buffer are split by software into back-to-back commands. The chip-select hold flag keeps the slave selected between those commands. A soft-reset bit aborts an in-flight command at any time. The serial clock runs at the system clock divided by twice the `HALF_DIV` parameter.

Top module: `spiu_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, every register reads 0 and every buffer word reads 0.
- R2: The buffer is 16 little-endian words at byte offsets 0x40..0x7C. A word written there reads back unchanged while the engine is idle.
- R3: Writing 1 to bit 18 of the command register (offset 0x00) starts a transfer. That bit reads 1 while the transfer runs and 0 once it has ended.
- R4: Bits [25:17] of the length register (offset 0x20) hold the bit count minus one. Exactly that many plus one SCK pulses are produced, anywhere from 1 to 512.
- R5: Bit i of a transfer is buffer byte i/8, bit 7-(i mod 8), so the first bit is the MSB of byte 0. MOSI changes only while SCK is low or on its falling edge, and it is stable at each rising edge.
- R6: When bit 0 of the mode register (offset 0x1c) is 1, MISO is sampled on each SCK rising edge and written into the bit position just sent. When that bit is 0, the buffer is left unchanged by the transfer.
- R7: When bit 27 of the mode register is 0, MOSI stays 0 for the whole transfer.
- R8: Chip select goes low on the clock edge that accepts the start. The first SCK rising edge follows 2*HALF_DIV clocks later. Each SCK half period lasts HALF_DIV clocks, and SCK is low whenever no transfer runs.
- R9: At the end of a transfer, chip select is set to the inverse of bit 30 of the hold register (offset 0x2c). With that bit at 1, chip select stays low into the next command.
- R10: Bit 4 of the status register (offset 0x30) is set on the edge where the last bit completes. A status write of 0 clears it. If a status write lands on that same edge, the set wins.
- R11: While a transfer runs, a further start, any buffer write and any write to the mode, length or hold registers have no effect.
- R12: Writing 1 to status bit 31 aborts any transfer on that edge. It releases chip select, drives SCK low and clears the done flag, and it keeps the mode, length and hold settings.
- R13: While status bit 30 is 1, start requests are ignored. That bit reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Two functions can meet on one clock edge. The first is the engine raising the done flag when the final bit completes. The second is a software write to the status register. The bench counts clocks from the accepted start, places a status write of 0 exactly on the completion edge, and expects done to read 1 afterwards. A second collision puts a start, a length write and a buffer write on edges inside a running command. The bench then judges them ignored by the pulse count, the chip-select waveform and a later read of the untouched buffer word.

// File: rtl/spiu_pkg.sv
package spiu_pkg;
   // register byte offsets
   localparam int unsigned OFF_CMD  = 32'h00;
   localparam int unsigned OFF_MODE = 32'h1c;
   localparam int unsigned OFF_LEN  = 32'h20;
   localparam int unsigned OFF_CSH  = 32'h2c;
   localparam int unsigned OFF_STAT = 32'h30;
   // field positions
   localparam int GO_BIT   = 18;
   localparam int DOUT_BIT = 27;
   localparam int DIN_BIT  = 0;
   localparam int LEN_LSB  = 17;
   localparam int HOLD_BIT = 30;
   localparam int DONE_BIT = 4;
   localparam int SLV_BIT  = 30;
   localparam int RST_BIT  = 31;

   typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_LOW, ST_HIGH} seq_state_t;
endpackage

// File: rtl/spiu_tick.sv
module spiu_tick #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CNT_W-1:0] TOP = CNT_W'(HALF_DIV - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (clr)          cnt_q <= '0;
      else if (cnt_q == TOP) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   assign tick = (cnt_q == TOP);
endmodule

// File: rtl/spiu_buf.sv
module spiu_buf #(
   parameter int BYTES = 64,
   parameter int WI_W  = 4,
   parameter int IDX_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WI_W-1:0]  wr_word,
   input  logic [31:0]      wr_data,
   input  logic [WI_W-1:0]  rd_word,
   output logic [31:0]      rd_data,
   input  logic             bit_we,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             bit_val,
   input  logic [IDX_W-1:0] peek_idx,
   output logic             peek_bit
);
   localparam int WORDS = BYTES / 4;

   logic [7:0]  mem   [BYTES];
   logic [31:0] words [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < BYTES; b++) mem[b] <= '0;
      end else begin
         if (wr_en) begin
            for (int b = 0; b < 4; b++) mem[{wr_word, 2'(b)}] <= wr_data[8*b +: 8];
         end
         if (bit_we) mem[bit_idx[IDX_W-1:3]][~bit_idx[2:0]] <= bit_val;
      end
   end

   // little-endian word view of the byte store
   genvar w;
   generate
      for (w = 0; w < WORDS; w++) begin : g_word
         assign words[w] = {mem[4*w+3], mem[4*w+2], mem[4*w+1], mem[4*w]};
      end
   endgenerate

   assign rd_data  = words[rd_word];
   assign peek_bit = mem[peek_idx[IDX_W-1:3]][~peek_idx[2:0]];
endmodule

// File: rtl/spiu_seq.sv
module spiu_seq
   import spiu_pkg::*;
#(
   parameter int IDX_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             start,
   input  logic             tick,
   input  logic [IDX_W-1:0] last_idx,
   input  logic             dout_en,
   input  logic             din_en,
   input  logic             hold,
   input  logic             miso,
   input  logic             peek_bit,
   output logic [IDX_W-1:0] peek_idx,
   output logic [IDX_W-1:0] cap_idx,
   output logic             cap_we,
   output logic             cap_val,
   output logic             sck,
   output logic             cs_n,
   output logic             mosi,
   output logic             busy,
   output logic             fin
);
   seq_state_t       state_q;
   logic [IDX_W-1:0] idx_q;
   logic             last_bit;

   assign busy     = (state_q != ST_IDLE);
   assign last_bit = (idx_q == last_idx);
   assign fin      = (state_q == ST_HIGH) && tick && last_bit && !srst;
   assign cap_we   = (state_q == ST_LOW) && tick && din_en && !srst;
   assign cap_val  = miso;
   assign cap_idx  = idx_q;

   always_comb begin
      case (state_q)
         ST_IDLE: peek_idx = '0;
         ST_HIGH: peek_idx = idx_q + 1'b1;
         default: peek_idx = idx_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         sck     <= 1'b0;
         cs_n    <= 1'b1;
         mosi    <= 1'b0;
      end else if (srst) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         sck     <= 1'b0;
         cs_n    <= 1'b1;
         mosi    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_LEAD;
               idx_q   <= '0;
               cs_n    <= 1'b0;
               mosi    <= dout_en & peek_bit;
            end
            ST_LEAD: if (tick) state_q <= ST_LOW;
            ST_LOW: if (tick) begin
               state_q <= ST_HIGH;
               sck     <= 1'b1;
            end
            ST_HIGH: if (tick) begin
               sck <= 1'b0;
               if (last_bit) begin
                  state_q <= ST_IDLE;
                  cs_n    <= ~hold;
               end else begin
                  state_q <= ST_LOW;
                  idx_q   <= idx_q + 1'b1;
                  mosi    <= dout_en & peek_bit;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_MOSI_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> $stable(mosi)); // R5
   AST_CS_LEADS_SCK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!cs_n && !sck)); // R8
   AST_SCK_REST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck); // R8
   AST_CS_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> (cs_n == !$past(hold))); // R9
endmodule

// File: rtl/spiu_engine.sv
module spiu_engine
   import spiu_pkg::*;
#(
   parameter int BUF_BYTES = 64,
   parameter int HALF_DIV  = 2,
   parameter int ADDR_W    = 7,
   parameter int BUF_BASE  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   localparam int BUF_WORDS = BUF_BYTES / 4;
   localparam int WI_W      = $clog2(BUF_WORDS);
   localparam int IDX_W     = $clog2(BUF_BYTES * 8);

   generate
      if (BUF_BYTES % 4 != 0 || BUF_BYTES < 8) begin : g_bad_bytes
         $error("BUF_BYTES must be a multiple of 4 and at least 8");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (BUF_BASE + BUF_BYTES > (1 << ADDR_W) || BUF_BASE <= int'(OFF_STAT)) begin : g_bad_map
         $error("buffer window must sit above the registers and inside the address space");
      end
      if (LEN_LSB + IDX_W > 32) begin : g_bad_len
         $error("length field does not fit a 32-bit register");
      end
   endgenerate

   // decode
   logic hit_cmd, hit_mode, hit_len, hit_csh, hit_stat, hit_buf;
   logic [ADDR_W-1:0] buf_off;
   logic unused_bits;

   assign hit_cmd  = (reg_addr == ADDR_W'(OFF_CMD));
   assign hit_mode = (reg_addr == ADDR_W'(OFF_MODE));
   assign hit_len  = (reg_addr == ADDR_W'(OFF_LEN));
   assign hit_csh  = (reg_addr == ADDR_W'(OFF_CSH));
   assign hit_stat = (reg_addr == ADDR_W'(OFF_STAT));
   assign hit_buf  = (int'(reg_addr) >= BUF_BASE) && (int'(reg_addr) < BUF_BASE + BUF_BYTES);
   assign buf_off  = reg_addr - ADDR_W'(BUF_BASE);
   assign unused_bits = ^{reg_wdata, reg_addr[1:0], buf_off};

   // engine wiring
   logic             busy, fin, tick, start, srst, cfg_ok;
   logic             cap_we, cap_val, peek_bit;
   logic [IDX_W-1:0] peek_idx, cap_idx;
   logic [31:0]      buf_rd;

   // configuration and status state
   logic             dout_en, din_en, hold_q, slave_q, done_q;
   logic [IDX_W-1:0] len_q;

   assign cfg_ok = reg_we && !busy;
   assign srst   = reg_we && hit_stat && reg_wdata[RST_BIT];
   assign start  = reg_we && hit_cmd && reg_wdata[GO_BIT] && !busy && !slave_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_en <= 1'b0;
         din_en  <= 1'b0;
         hold_q  <= 1'b0;
         len_q   <= '0;
      end else if (cfg_ok) begin
         if (hit_mode) begin
            dout_en <= reg_wdata[DOUT_BIT];
            din_en  <= reg_wdata[DIN_BIT];
         end
         if (hit_len) len_q  <= reg_wdata[LEN_LSB +: IDX_W];
         if (hit_csh) hold_q <= reg_wdata[HOLD_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slave_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         if (reg_we && hit_stat) slave_q <= reg_wdata[SLV_BIT];
         if (srst)                    done_q <= 1'b0;
         else if (fin)                done_q <= 1'b1;
         else if (reg_we && hit_stat) done_q <= reg_wdata[DONE_BIT];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (hit_cmd) reg_rdata[GO_BIT] = busy;
      if (hit_mode) begin
         reg_rdata[DOUT_BIT] = dout_en;
         reg_rdata[DIN_BIT]  = din_en;
      end
      if (hit_len) reg_rdata[LEN_LSB +: IDX_W] = len_q;
      if (hit_csh) reg_rdata[HOLD_BIT] = hold_q;
      if (hit_stat) begin
         reg_rdata[SLV_BIT]  = slave_q;
         reg_rdata[DONE_BIT] = done_q;
      end
      if (hit_buf) reg_rdata = buf_rd;
   end

   spiu_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!busy),
      .tick  (tick)
   );

   spiu_buf #(.BYTES(BUF_BYTES), .WI_W(WI_W), .IDX_W(IDX_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_ok && hit_buf),
      .wr_word  (buf_off[WI_W+1:2]),
      .wr_data  (reg_wdata),
      .rd_word  (buf_off[WI_W+1:2]),
      .rd_data  (buf_rd),
      .bit_we   (cap_we),
      .bit_idx  (cap_idx),
      .bit_val  (cap_val),
      .peek_idx (peek_idx),
      .peek_bit (peek_bit)
   );

   spiu_seq #(.IDX_W(IDX_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .srst     (srst),
      .start    (start),
      .tick     (tick),
      .last_idx (len_q),
      .dout_en  (dout_en),
      .din_en   (din_en),
      .hold     (hold_q),
      .miso     (spi_miso),
      .peek_bit (peek_bit),
      .peek_idx (peek_idx),
      .cap_idx  (cap_idx),
      .cap_we   (cap_we),
      .cap_val  (cap_val),
      .sck      (spi_sck),
      .cs_n     (spi_cs_n),
      .mosi     (spi_mosi),
      .busy     (busy),
      .fin      (fin)
   );

   AST_DONE_ON_FIN: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> done_q); // R10
   AST_SRST_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (!busy && spi_cs_n && !spi_sck && !done_q)); // R12
   AST_LEN_LOCKED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(len_q)); // R11
   AST_NO_START_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_q && !busy) |=> !busy); // R13
endmodule

// File: tb/spiu_engine_tb.sv
module spiu_engine_tb;
   localparam int CLK_PERIOD = 10;
   localparam int H = 2;
   localparam logic [6:0] A_CMD = 7'h00, A_MODE = 7'h1c, A_LEN = 7'h20,
                          A_CSH = 7'h2c, A_STAT = 7'h30, A_BUF = 7'h40;

   logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, miso = 1'b0;
   logic [6:0]  addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic sck, cs_n, mosi;

   always #(CLK_PERIOD/2) clk = ~clk;

   spiu_engine #(.BUF_BYTES(64), .HALF_DIV(H), .ADDR_W(7), .BUF_BASE(64)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
   );

   int n_chk = 0, n_fail = 0;

   // reference model state
   bit act = 0, hold_m = 0, idle_cs = 1, prev_sck = 0, cur_din = 0;
   int k = 0, nb = 0, rise_cnt = 0;
   bit tx_mem [0:512];
   bit rx_mem [0:512];
   logic [7:0] ref_mem [0:63];

   task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, a, e);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   // per-cycle model of SCK / chip select plus a behavioural slave
   always @(negedge clk) begin
      bit es;
      bit ec;
      int q;
      if (rst_n) begin
         es = 1'b0;
         ec = idle_cs;
         if (act) begin
            ec = 1'b0;
            if (k >= H) begin
               q = k - H;
               if (q < 2*nb*H) es = ((q % (2*H)) >= H);
               else begin
                  ec = !hold_m;
                  idle_cs = !hold_m;
                  act = 0;
               end
            end
            k++;
         end
         chk(sck === es, "R8 sck waveform", 32'(sck), 32'(es));
         chk(cs_n === ec, "R9 cs_n waveform", 32'(cs_n), 32'(ec));
         if (sck && !prev_sck && rise_cnt < 512) begin
            chk(mosi === tx_mem[rise_cnt], "R5 mosi bit at rising edge", 32'(mosi), 32'(tx_mem[rise_cnt]));
            rise_cnt++;
         end
         if (!sck) miso <= rx_mem[rise_cnt];
         prev_sck = sck;
      end
   end

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1 we = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic set_word(input int w, input logic [31:0] d);
      for (int b = 0; b < 4; b++) ref_mem[4*w+b] = d[8*b +: 8];
      wr(7'(A_BUF + 4*w), d);
   endtask

   task automatic check_buf(input string req);
      logic [31:0] d;
      for (int w = 0; w < 16; w++) begin
         rd(7'(A_BUF + 4*w), d);
         chk(d === {ref_mem[4*w+3], ref_mem[4*w+2], ref_mem[4*w+1], ref_mem[4*w]}, req, d,
             {ref_mem[4*w+3], ref_mem[4*w+2], ref_mem[4*w+1], ref_mem[4*w]});
      end
   endtask

   task automatic launch(input int nbits, input bit hold, input bit dout, input bit din);
      wr(A_MODE, (32'(dout) << 27) | 32'(din));
      wr(A_LEN, 32'(nbits - 1) << 17);
      wr(A_CSH, 32'(hold) << 30);
      wr(A_STAT, 32'h0);
      for (int i = 0; i < 513; i++) begin
         rx_mem[i] = (i < nbits) ? 1'($urandom) : 1'b0;
         tx_mem[i] = (i < nbits && dout) ? ref_mem[i/8][7-(i%8)] : 1'b0;
      end
      cur_din = din;
      wr(A_CMD, 32'h1 << 18);
      act = 1; k = 0; nb = nbits; hold_m = hold; rise_cnt = 0;
   endtask

   task automatic wait_end();
      logic [31:0] d;
      while (act) @(posedge clk);
      rd(A_STAT, d);
      chk(d[4] === 1'b1, "R10 done set at end", d, 32'h10);
      rd(A_CMD, d);
      chk(d[18] === 1'b0, "R3 start bit cleared at end", d, 32'h0);
      chk(rise_cnt == nb, "R4 SCK pulse count", 32'(rise_cnt), 32'(nb));
      if (cur_din)
         for (int i = 0; i < nb; i++) ref_mem[i/8][7-(i%8)] = rx_mem[i];
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      logic [31:0] d;
      for (int i = 0; i < 64; i++) ref_mem[i] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      chk(cs_n === 1'b1 && sck === 1'b0, "R1 reset pins", {cs_n, sck}, 32'h2);
      rd(A_STAT, d); chk(d === 32'h0, "R1 status after reset", d, 32'h0);
      rd(A_CMD, d);  chk(d === 32'h0, "R1 command after reset", d, 32'h0);
      rd(A_LEN, d);  chk(d === 32'h0, "R1 length after reset", d, 32'h0);
      check_buf("R1 buffer after reset");

      // R2 buffer words
      for (int w = 0; w < 16; w++) set_word(w, 32'hA5C3_0F96 ^ (32'(w) * 32'h0103_0507));
      check_buf("R2 buffer write/read");

      // R3 R5 R6 R8 four-byte full-duplex transfer
      launch(32, 0, 1, 1);
      rd(A_CMD, d); chk(d[18] === 1'b1, "R3 start bit reads busy", d, 32'h4_0000);
      wait_end();
      check_buf("R6 captured data");

      // R4 odd bit count
      launch(13, 0, 1, 1);
      wait_end();
      check_buf("R4 partial byte capture");

      // R9 hold chip select across commands
      launch(16, 1, 1, 1);
      wait_end();
      chk(cs_n === 1'b0, "R9 cs held low", 32'(cs_n), 32'h0);
      launch(8, 0, 1, 1);
      wait_end();
      chk(cs_n === 1'b1, "R9 cs released", 32'(cs_n), 32'h1);
      check_buf("R9 buffer after chained commands");

      // R7 data-out disabled
      launch(24, 0, 0, 1);
      wait_end();
      check_buf("R7 buffer after silent transmit");

      // R6 capture disabled: buffer unchanged
      launch(24, 0, 1, 0);
      wait_end();
      check_buf("R6 buffer unchanged without capture");

      // R11 writes during a transfer are ignored
      launch(64, 0, 1, 1);
      repeat (5) @(posedge clk);
      wr(A_CMD, 32'h1 << 18);
      wr(7'(A_BUF + 60), 32'hDEAD_BEEF);
      wr(A_LEN, 32'(7) << 17);
      wait_end();
      rd(A_LEN, d); chk(d === 32'(63) << 17, "R11 length kept during busy", d, 32'(63) << 17);
      check_buf("R11 buffer write ignored while busy");

      // R10 done set wins over same-edge status write
      launch(8, 0, 1, 1);
      repeat (H + 2*8*H - 1) @(posedge clk);
      wr(A_STAT, 32'h0);
      wait_end();
      wr(A_STAT, 32'h0);
      rd(A_STAT, d); chk(d[4] === 1'b0, "R10 done cleared by write", d, 32'h0);
      check_buf("R10 buffer after collision");

      // R4 full buffer
      launch(512, 0, 1, 1);
      wait_end();
      check_buf("R4 full-length capture");

      // R12 soft reset mid transfer
      launch(64, 1, 1, 1);
      repeat (20) @(posedge clk);
      wr(A_STAT, 32'h8000_0000);
      act = 0; idle_cs = 1;
      rd(A_STAT, d); chk(d === 32'h0, "R12 done clear after soft reset", d, 32'h0);
      rd(A_CMD, d);  chk(d === 32'h0, "R12 idle after soft reset", d, 32'h0);
      rd(A_LEN, d);  chk(d === 32'(63) << 17, "R12 length kept", d, 32'(63) << 17);
      rd(A_CSH, d);  chk(d === 32'h4000_0000, "R12 hold kept", d, 32'h4000_0000);
      for (int i = 0; i < rise_cnt; i++) ref_mem[i/8][7-(i%8)] = rx_mem[i];
      check_buf("R12 buffer after abort");

      // R13 start ignored in slave setting
      wr(A_STAT, 32'h4000_0000);
      wr(A_CMD, 32'h1 << 18);
      repeat (10) @(posedge clk);
      rd(A_CMD, d);  chk(d === 32'h0, "R13 start ignored", d, 32'h0);
      rd(A_STAT, d); chk(d === 32'h4000_0000, "R13 mode bit readback", d, 32'h4000_0000);
      wr(A_STAT, 32'h0);
      repeat (4) @(posedge clk);

      summary();
   end
endmodule